// File: doc/BRIEF.md
# Posted Write Flow-Through Controller

This controller decides how a posted memory write burst moves from the posted write FIFO onto the target bus. When the target bus is granted while the initiator is still writing, the controller enters flow-through. In this mode the target-side burst streams out while the FIFO is still being filled. If the initiator has already finished when the grant arrives, the burst is drained as an ordinary fully posted write.

While streaming, the controller watches two things. The first is how far the FIFO has fallen behind: too few Dwords to reach the next cache line boundary causes an underrun stop. The second is how close the target address is to a large aligned region edge, which causes a disconnect back to the initiator. It issues a one-cycle start strobe to the target-side master, a one-cycle terminate strobe that ends the target burst, and a one-cycle disconnect request toward the initiator side. Memory write and memory write-and-invalidate are handled the same way.

Top module: `pwft_ctrl`

## Requirements
- R1: After reset, mst_start, mst_term, init_disc, ft_mode and busy are all 0.
- R2: A burst is accepted only when all of these hold in one cycle: the controller is idle, tgt_grant is 1, cmd is an accepted write code and fifo_cnt is non-zero. mst_start then pulses in the next cycle, and busy rises with it.
- R3: Any cmd value other than 4'b0111 (memory write) or 4'b1111 (memory write-and-invalidate) never starts a burst, whatever the grant and FIFO state.
- R4: ft_mode, in the cycle of mst_start, equals init_active sampled on the accepting edge. It stays at that value until the burst ends.
- R5: A burst accepted with init_active low is a plain posted drain. It never raises init_disc. It terminates when fifo_cnt is 0, or when a Dword moves (xfer) with fifo_cnt equal to 1.
- R6: While ft_mode is 1 and init_active is 1, the queue-empty condition is fifo_cnt < CLS - (dw_ofs mod CLS). When it holds, mst_term pulses on the next cycle and busy falls with it.
- R7: cls_sel selects the cache line size in Dwords: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32.
- R8: While ft_mode is 1 and init_active is 1, a Dword moved (xfer) with all bits of dw_ofs set is the last Dword before an aligned boundary. init_disc then pulses on the next cycle.
- R9: mst_start, mst_term and init_disc are single-cycle pulses. Each of them occurs at most once per burst.
- R10: Memory write-and-invalidate follows exactly the same start, queue-empty, boundary and drain rules as memory write.
- R11: Once init_active falls during a flow-through burst, the queue-empty rule stops applying and the burst drains as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tgt_grant | input | 1 | Target bus granted to this block's master |
| init_active | input | 1 | Initiator-side write transaction still in progress |
| cmd | input | 4 | Bus command of the queued write |
| cls_sel | input | 2 | Target-bus cache line size select |
| fifo_cnt | input | CNT_W | Dwords currently held in the posted write FIFO |
| dw_ofs | input | BND_LOG2 | Dword offset of the next target Dword inside the disconnect region |
| xfer | input | 1 | One Dword moves to the target bus this cycle |
| mst_start | output | 1 | Pulse: begin the target-side burst |
| mst_term | output | 1 | Pulse: end the target-side burst |
| init_disc | output | 1 | Pulse: request a target disconnect on the initiator bus |
| ft_mode | output | 1 | Current burst was started in flow-through |
| busy | output | 1 | A burst is in progress |

## Verification
The hardest case to reach is a disconnect boundary crossed during flow-through. The initiator must still be active, and the FIFO must stay deep enough that the queue-empty stop does not end the burst first. The stimulus gets there in two steps. It tops the FIFO up by one Dword for every Dword drained, and it starts the burst a few Dwords below the region edge with a deep FIFO. The bench then drops the initiator and checks that the remainder drains as a plain posted burst. It also runs the same address and count under every cache line size, so the queue-empty threshold falls on both sides of the FIFO count.

// File: rtl/pwft_ctrl.sv
module pwft_ctrl #(
  parameter int CNT_W    = 7,
  parameter int BND_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tgt_grant,
  input  logic                init_active,
  input  logic [3:0]          cmd,
  input  logic [1:0]          cls_sel,
  input  logic [CNT_W-1:0]    fifo_cnt,
  input  logic [BND_LOG2-1:0] dw_ofs,
  input  logic                xfer,
  output logic                mst_start,
  output logic                mst_term,
  output logic                init_disc,
  output logic                ft_mode,
  output logic                busy
);
  localparam logic [3:0] CMD_MW  = 4'b0111;
  localparam logic [3:0] CMD_MWI = 4'b1111;
  localparam int         CW      = (CNT_W > 6) ? CNT_W : 6;

  logic busy_q, flow_q, disc_q;

  wire       cmd_ok  = (cmd == CMD_MW) || (cmd == CMD_MWI);
  wire       start_c = !busy_q && tgt_grant && cmd_ok && (|fifo_cnt);

  wire [5:0] cls     = 6'd4 << cls_sel;
  wire [5:0] off     = {1'b0, dw_ofs[4:0]} & (cls - 6'd1);
  wire [5:0] rem     = cls - off;

  wire       stream  = busy_q && flow_q && init_active;
  wire       qe_c    = stream && (CW'(fifo_cnt) < CW'(rem));
  wire       drain_c = busy_q && !stream &&
                       ((fifo_cnt == '0) || (xfer && fifo_cnt == CNT_W'(1)));
  wire       end_c   = qe_c || drain_c;
  wire       bnd_c   = stream && xfer && (&dw_ofs) && !disc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      flow_q    <= 1'b0;
      disc_q    <= 1'b0;
      mst_start <= 1'b0;
      mst_term  <= 1'b0;
      init_disc <= 1'b0;
    end else begin
      mst_start <= start_c;
      mst_term  <= end_c;
      init_disc <= bnd_c;
      if (start_c) begin
        busy_q <= 1'b1;
        flow_q <= init_active;
        disc_q <= 1'b0;
      end else begin
        if (end_c) busy_q <= 1'b0;
        if (bnd_c) disc_q <= 1'b1;
      end
    end
  end

  assign ft_mode = busy_q & flow_q;
  assign busy    = busy_q;
endmodule

module pwft_ctrl_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tgt_grant,
  input logic             init_active,
  input logic [3:0]       cmd,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             xfer,
  input logic             mst_start,
  input logic             mst_term,
  input logic             init_disc,
  input logic             ft_mode,
  input logic             busy
);
  p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |=> !mst_start);
  p_term_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mst_term |=> !mst_term);
  p_disc_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_disc |=> !init_disc);
  p_start_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |-> ($past(tgt_grant) && $past(fifo_cnt) != '0 && busy));
  p_start_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |-> ($past(cmd) == 4'b0111 || $past(cmd) == 4'b1111));
  p_ft_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |-> (ft_mode == $past(init_active)));
  p_disc_flow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_disc |-> ($past(ft_mode) && $past(init_active) && $past(xfer)));
  p_posted_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ft_mode && fifo_cnt == '0) |=> (mst_term && !busy));
  p_term_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mst_term |-> !busy);
endmodule

bind pwft_ctrl pwft_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tgt_grant(tgt_grant), .init_active(init_active),
  .cmd(cmd), .fifo_cnt(fifo_cnt), .xfer(xfer), .mst_start(mst_start),
  .mst_term(mst_term), .init_disc(init_disc), .ft_mode(ft_mode), .busy(busy)
);

// File: tb/pwft_ctrl_tb.sv
module pwft_ctrl_tb;
  localparam int CNT_W = 7;
  localparam int BND_LOG2 = 10;
  localparam int BND = 1 << BND_LOG2;

  logic clk = 0, rst_n = 0;
  logic tgt_grant = 0, init_active = 0, xfer = 0;
  logic [3:0] cmd = 0;
  logic [1:0] cls_sel = 0;
  logic [CNT_W-1:0] fifo_cnt = 0;
  logic [BND_LOG2-1:0] dw_ofs = 0;
  logic mst_start, mst_term, init_disc, ft_mode, busy;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  int addr = 0, cnt = 0;

  bit m_busy = 0, m_flow = 0, m_disc = 0;
  bit e_start = 0, e_term = 0, e_disc = 0;

  always #4 clk = ~clk;

  pwft_ctrl #(.CNT_W(CNT_W), .BND_LOG2(BND_LOG2)) u_dut (
    .clk(clk), .rst_n(rst_n), .tgt_grant(tgt_grant), .init_active(init_active),
    .cmd(cmd), .cls_sel(cls_sel), .fifo_cnt(fifo_cnt), .dw_ofs(dw_ofs),
    .xfer(xfer), .mst_start(mst_start), .mst_term(mst_term),
    .init_disc(init_disc), .ft_mode(ft_mode), .busy(busy));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_flow = 0; m_disc = 0;
      e_start = 0; e_term = 0; e_disc = 0;
    end else begin
      e_start = 0; e_term = 0; e_disc = 0;
      if (!m_busy) begin
        if (tgt_grant && (cmd == 4'h7 || cmd == 4'hF) && fifo_cnt != 0) begin
          m_busy = 1; m_flow = init_active; m_disc = 0; e_start = 1;
        end
      end else begin
        int cls, rem;
        bit fin;
        cls = 4 << cls_sel;
        rem = cls - (int'(dw_ofs) % cls);
        if (m_flow && init_active && xfer && int'(dw_ofs) == BND - 1 && !m_disc) begin
          e_disc = 1; m_disc = 1;
        end
        if (m_flow && init_active) fin = int'(fifo_cnt) < rem;
        else fin = (fifo_cnt == 0) || (xfer && fifo_cnt == 1);
        if (fin) begin e_term = 1; m_busy = 0; end
      end
    end
  end

  task automatic chk(input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("mst_start", mst_start, e_start);
    chk("mst_term", mst_term, e_term);
    chk("init_disc", init_disc, e_disc);
    chk("ft_mode", ft_mode, m_busy && m_flow);
    chk("busy", busy, m_busy);
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic burst(input string t, input logic [3:0] c, input logic [1:0] s,
                       input bit init0, input int a0, input int n0,
                       input int fillper, input int drop_at, input int maxc);
    bit started = 0;
    tag = t; cmd = c; cls_sel = s; init_active = init0;
    addr = a0; cnt = n0; tgt_grant = 1;
    for (int i = 0; i < maxc; i++) begin
      bit fill;
      xfer = (m_busy && cnt > 0);
      fill = init_active && fillper > 0 && (i % fillper == 0) && cnt < 120;
      fifo_cnt = CNT_W'(cnt);
      dw_ofs = BND_LOG2'(addr);
      @(negedge clk);
      cnt = cnt - int'(xfer) + int'(fill);
      addr = addr + int'(xfer);
      if (m_busy) tgt_grant = 0;
      if (i == drop_at) init_active = 0;
      if (started && !m_busy) break;
      started = started | m_busy;
    end
    tgt_grant = 0; xfer = 0; init_active = 0; cnt = 0; fifo_cnt = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2: no grant, no start
    tag = "R2"; cmd = 4'h7; fifo_cnt = 8; init_active = 1;
    repeat (4) @(negedge clk);
    fifo_cnt = 0; init_active = 0;
    burst("R3", 4'h6, 2'd1, 1, 'h10, 8, 1, -1, 6);
    burst("R3", 4'h3, 2'd1, 0, 'h10, 8, 1, -1, 6);
    burst("R6", 4'h7, 2'd1, 1, 'h100, 10, 2, -1, 60);
    burst("R6", 4'h7, 2'd2, 1, 'h105, 14, 3, -1, 60);
    burst("R8 R11", 4'h7, 2'd3, 1, 'h3F0, 40, 1, 30, 200);
    burst("R5", 4'h7, 2'd0, 0, 'h20, 5, 0, -1, 40);
    burst("R5", 4'h7, 2'd3, 0, 'h3FD, 6, 0, -1, 40);
    burst("R10", 4'hF, 2'd2, 1, 'h7F8, 30, 1, 20, 200);
    burst("R10", 4'hF, 2'd1, 1, 'h200, 9, 2, -1, 60);
    for (int s = 0; s < 4; s++)
      burst("R7", 4'h7, 2'(s), 1, 'h42, 5, 0, 2, 40);
    burst("R4", 4'h7, 2'd0, 1, 'h8, 1, 0, 0, 20);
    tag = "R9";
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule